// File: doc/BRIEF.md
# Control Flow Signature Watchdog

This watchdog runs beside a processor and watches the same instruction words the processor fetches. It splits the stream into nodes, where a node is a run of instructions that ends with a branch. While a node is running, it folds every fetched word into a 32-bit signature. The fold is either a plain XOR or a multiple-input shift register, chosen at run time. When the processor flags the branch that ends the node, the watchdog does two checks:

- The final signature, which includes the branch word, must equal the reference signature stored for the current node.
- The branch target node must be one of the successors listed for the current node in a small program-graph table.

A reference channel writes the table, one whole node entry per write. A node that runs too many instructions without a branch is reported as a hang. The error is held until software clears it. A 2-bit code tells which check failed first.

Top module: `cfsig_watchdog`

## Requirements
- R1: After reset, `err_flag` is 0, `err_code` is 2'b00 and `cur_node` is 0.
- R2: With `lfsr_mode`=0, a node's signature is the XOR of all its accepted words, the branch word included. At the branch, a difference from the stored reference gives `err_code`=2'b01 on the cycle after the branch is accepted.
- R3: With `lfsr_mode`=1, each accepted word updates the signature as `s' = {s[30:0],1'b0} ^ (s[31] ? 32'h04C11DB7 : 0) ^ word`, starting from 0. A mismatch at the branch is reported as in R2.
- R4: Each node's signature and instruction count start from zero. A correct node that follows another node raises no error.
- R5: At a branch, `cur_node` takes `branch_tgt`. If the target equals no enabled successor of the old node, `err_code`=2'b10 is reported. This holds even when the target is the node itself.
- R6: If one branch has both a signature mismatch and an illegal target, the code is 2'b01.
- R7: When `max_len` is non-zero, a non-branch word that is the `max_len`-th word of a node gives `err_code`=2'b11, and the count of words in the node restarts at zero. A node of exactly `max_len` words whose last word is the branch is legal. `max_len`=0 turns the check off.
- R8: Once raised, `err_flag` and `err_code` hold their values, whatever errors follow, until `err_clear` is asserted.
- R9: `err_clear` drops the flag one cycle later. If an error is detected in the same cycle as the clear, that error's code is loaded instead.
- R10: While `ins_valid` is 0, `ins_word`, `ins_branch` and `branch_tgt` have no effect.
- R11: A write with `ref_we` replaces a node's whole entry:
  - the reference signature, from `ref_sig`;
  - successor 0 from `ref_succ[3:0]` and successor 1 from `ref_succ[7:4]`;
  - the enables, from `ref_succ_en`, where bit k enables successor k.

  Branches in later cycles check against the new entry. After reset, every entry is zero with no successor enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lfsr_mode | input | 1 | 1: shift-register fold, 0: XOR fold |
| max_len | input | 8 | Maximum node length in words, 0 disables the check |
| ins_valid | input | 1 | A fetched instruction word is present |
| ins_word | input | 32 | Fetched instruction word |
| ins_branch | input | 1 | The present word is the branch that ends the node |
| branch_tgt | input | 4 | Node entered by the branch |
| ref_we | input | 1 | Write one table entry |
| ref_node | input | 4 | Entry being written |
| ref_sig | input | 32 | Reference signature for that node |
| ref_succ | input | 8 | Two successor IDs, successor 0 in the low nibble |
| ref_succ_en | input | 2 | Enable bit for each successor |
| err_clear | input | 1 | Clear the held error |
| err_flag | output | 1 | An error is held |
| err_code | output | 2 | 01 signature, 10 illegal arc, 11 timeout |
| cur_node | output | 4 | Node currently executing |

## Verification
Every error is detected from the word presented in the cycle of the accepting edge and is registered at that edge. So `err_flag` and `err_code` are due exactly one edge after the offending word, and `cur_node` is also due one edge after the branch. A clear is seen one edge after `err_clear`. The bench drives each word on a falling edge and compares all three outputs with its reference model on the next falling edge. Each compare therefore falls one half period after the edge that produced the result. Table writes are done in their own cycles, so the bench never depends on how a write is ordered against a branch in the same cycle.

// File: rtl/cfsw_pkg.sv
// Shared definitions for the control flow signature watchdog.
// Assumes: the error codes are visible at the top-level port, so their
// values are fixed.
package cfsw_pkg;

    typedef enum logic [1:0] {
        ERR_NONE = 2'b00,
        ERR_SIG  = 2'b01,
        ERR_ARC  = 2'b10,
        ERR_TIME = 2'b11
    } err_code_e;

endpackage

// File: rtl/cfsw_sig_acc.sv
// Signature accumulator: folds every accepted instruction word into a
// running signature and gives out the value the signature would take
// with the current word included, so the top can compare it at a branch.
// Assumes: the word with the branch flag is the last word of its node.
// The accumulator restarts from zero after that word.
module cfsw_sig_acc #(
    parameter int          W    = 32,
    parameter logic [W-1:0] POLY = 32'h04C11DB7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         valid,
    input  logic         is_branch,
    input  logic         lfsr_mode,
    input  logic [W-1:0] word,
    output logic [W-1:0] sig_final
);

    logic [W-1:0] acc;
    logic [W-1:0] shifted;

    // Shift-register step with feedback through the polynomial
    always_comb begin
        shifted = {acc[W-2:0], 1'b0};
        if (acc[W-1]) begin
            shifted = shifted ^ POLY;
        end
    end

    // Pick the fold selected for this word
    always_comb begin
        if (lfsr_mode) begin
            sig_final = shifted ^ word;
        end else begin
            sig_final = acc ^ word;
        end
    end

    // Hold the running value; restart after the closing branch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (valid) begin
            acc <= is_branch ? '0 : sig_final;
        end
    end

    AST_ACC_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        valid && is_branch |=> acc == '0); // R4
    AST_ACC_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> $stable(acc)); // R10

endmodule

// File: rtl/cfsw_graph_tab.sv
// Program-graph table: for each node it stores the reference signature
// and a small list of successor IDs, each with an enable bit. It reads
// out the entry of the running node and reports whether a branch target
// is an allowed successor.
// Assumes: NODES is a power of two, so every node ID addresses an entry.
module cfsw_graph_tab #(
    parameter int NODES = 16,
    parameter int NSUCC = 2,
    parameter int W     = 32,
    localparam int NODE_W = $clog2(NODES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [NODE_W-1:0]       wr_node,
    input  logic [W-1:0]            wr_sig,
    input  logic [NSUCC*NODE_W-1:0] wr_succ,
    input  logic [NSUCC-1:0]        wr_succ_en,
    input  logic [NODE_W-1:0]       rd_node,
    input  logic [NODE_W-1:0]       tgt,
    output logic [W-1:0]            exp_sig,
    output logic                    arc_ok
);

    logic [W-1:0]      sig_mem  [NODES];
    logic [NODE_W-1:0] succ_mem [NODES][NSUCC];
    logic [NSUCC-1:0]  en_mem   [NODES];
    logic [NSUCC-1:0]  hit;

    // Store one whole entry per write; reset empties the table
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int n = 0; n < NODES; n++) begin
                sig_mem[n] <= '0;
                en_mem[n]  <= '0;
                for (int k = 0; k < NSUCC; k++) begin
                    succ_mem[n][k] <= '0;
                end
            end
        end else if (wr_en) begin
            sig_mem[wr_node] <= wr_sig;
            en_mem[wr_node]  <= wr_succ_en;
            for (int k = 0; k < NSUCC; k++) begin
                succ_mem[wr_node][k] <= wr_succ[k*NODE_W +: NODE_W];
            end
        end
    end

    // One comparator per successor slot
    for (genvar k = 0; k < NSUCC; k++) begin : g_succ
        assign hit[k] = en_mem[rd_node][k] && (succ_mem[rd_node][k] == tgt);
    end

    assign exp_sig = sig_mem[rd_node];
    assign arc_ok  = |hit;

    AST_ENTRY_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> sig_mem[$past(wr_node)] == $past(wr_sig)); // R11

endmodule

// File: rtl/cfsw_len_timer.sv
// Node length timer: counts the words of the running node and flags a
// hang when the node reaches its maximum length on a word that is not a
// branch.
// Assumes: max_len = 0 turns the check off. After a hang the count
// restarts, so a long hang is flagged again every max_len words.
module cfsw_len_timer #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid,
    input  logic             is_branch,
    input  logic [LEN_W-1:0] max_len,
    output logic             timeout
);

    logic [LEN_W-1:0] len;
    logic [LEN_W-1:0] last_idx;

    // Index of the last word a node may hold
    always_comb begin
        last_idx = max_len - 1'b1;
        timeout  = valid && !is_branch && (max_len != '0) && (len == last_idx);
    end

    // Count words; restart on a branch or a hang
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len <= '0;
        end else if (valid) begin
            if (is_branch || timeout) begin
                len <= '0;
            end else begin
                len <= len + 1'b1;
            end
        end
    end

    AST_LEN_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        valid && (is_branch || timeout) |=> len == '0); // R7

endmodule

// File: rtl/cfsig_watchdog.sv
// Control flow signature watchdog, top level. It tracks the running
// node, checks the signature and the successor arc at every branch,
// checks node length, and holds the first error it sees until cleared.
// Assumes: branch_tgt is valid in the cycle the branch word is accepted.
// When two errors arrive in one cycle, a signature error wins over an
// arc error.
module cfsig_watchdog
    import cfsw_pkg::*;
#(
    parameter int           NODES = 16,
    parameter int           NSUCC = 2,
    parameter int           W     = 32,
    parameter int           LEN_W = 8,
    parameter logic [W-1:0] POLY  = 32'h04C11DB7,
    localparam int          NODE_W = $clog2(NODES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    lfsr_mode,
    input  logic [LEN_W-1:0]        max_len,
    input  logic                    ins_valid,
    input  logic [W-1:0]            ins_word,
    input  logic                    ins_branch,
    input  logic [NODE_W-1:0]       branch_tgt,
    input  logic                    ref_we,
    input  logic [NODE_W-1:0]       ref_node,
    input  logic [W-1:0]            ref_sig,
    input  logic [NSUCC*NODE_W-1:0] ref_succ,
    input  logic [NSUCC-1:0]        ref_succ_en,
    input  logic                    err_clear,
    output logic                    err_flag,
    output logic [1:0]              err_code,
    output logic [NODE_W-1:0]       cur_node
);

    logic [W-1:0] sig_final;
    logic [W-1:0] exp_sig;
    logic         arc_ok;
    logic         timeout;
    logic         brk;
    logic         sig_bad;
    logic         arc_bad;
    err_code_e    new_code;
    err_code_e    held_code;

    cfsw_sig_acc #(.W(W), .POLY(POLY)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid     (ins_valid),
        .is_branch (ins_branch),
        .lfsr_mode (lfsr_mode),
        .word      (ins_word),
        .sig_final (sig_final)
    );

    cfsw_graph_tab #(.NODES(NODES), .NSUCC(NSUCC), .W(W)) u_tab (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (ref_we),
        .wr_node    (ref_node),
        .wr_sig     (ref_sig),
        .wr_succ    (ref_succ),
        .wr_succ_en (ref_succ_en),
        .rd_node    (cur_node),
        .tgt        (branch_tgt),
        .exp_sig    (exp_sig),
        .arc_ok     (arc_ok)
    );

    cfsw_len_timer #(.LEN_W(LEN_W)) u_len (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid     (ins_valid),
        .is_branch (ins_branch),
        .max_len   (max_len),
        .timeout   (timeout)
    );

    // Classify this cycle's error by priority
    always_comb begin
        brk     = ins_valid && ins_branch;
        sig_bad = brk && (sig_final != exp_sig);
        arc_bad = brk && !arc_ok;
        if (sig_bad) begin
            new_code = ERR_SIG;
        end else if (arc_bad) begin
            new_code = ERR_ARC;
        end else if (timeout) begin
            new_code = ERR_TIME;
        end else begin
            new_code = ERR_NONE;
        end
    end

    // Move to the branch target node
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_node <= '0;
        end else if (brk) begin
            cur_node <= branch_tgt;
        end
    end

    // Hold the first error until a clear; a clear takes a new error
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_flag  <= 1'b0;
            held_code <= ERR_NONE;
        end else if (!err_flag || err_clear) begin
            err_flag  <= (new_code != ERR_NONE);
            held_code <= new_code;
        end
    end

    assign err_code = held_code;

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag && !err_clear |=> err_flag && $stable(err_code)); // R8
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        err_clear && !sig_bad && !arc_bad && !timeout |=> !err_flag); // R9
    AST_SIG_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_flag || err_clear) && sig_bad |=> err_code == ERR_SIG); // R6
    AST_NODE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid && ins_branch |=> cur_node == $past(branch_tgt)); // R5

endmodule

// File: tb/cfsig_watchdog_tb_top.sv
module cfsig_watchdog_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NN = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lfsr_mode = 1'b0;
    logic [7:0]  max_len = 8'd0;
    logic        ins_valid = 1'b0;
    logic [31:0] ins_word = '0;
    logic        ins_branch = 1'b0;
    logic [3:0]  branch_tgt = '0;
    logic        ref_we = 1'b0;
    logic [3:0]  ref_node = '0;
    logic [31:0] ref_sig = '0;
    logic [7:0]  ref_succ = '0;
    logic [1:0]  ref_succ_en = '0;
    logic        err_clear = 1'b0;
    logic        err_flag;
    logic [1:0]  err_code;
    logic [3:0]  cur_node;

    int n_chk = 0;
    int n_bad = 0;

    // reference model state
    logic [31:0] m_acc = '0;
    int          m_len = 0;
    logic [3:0]  m_cur = '0;
    logic        m_flag = 1'b0;
    logic [1:0]  m_code = '0;
    logic [31:0] m_sig [NN];
    logic [3:0]  m_s0 [NN];
    logic [3:0]  m_s1 [NN];
    logic [1:0]  m_en [NN];

    always #(CLK_PERIOD/2) clk = ~clk;

    cfsig_watchdog dut_i (
        .clk(clk), .rst_n(rst_n), .lfsr_mode(lfsr_mode), .max_len(max_len),
        .ins_valid(ins_valid), .ins_word(ins_word), .ins_branch(ins_branch),
        .branch_tgt(branch_tgt), .ref_we(ref_we), .ref_node(ref_node),
        .ref_sig(ref_sig), .ref_succ(ref_succ), .ref_succ_en(ref_succ_en),
        .err_clear(err_clear), .err_flag(err_flag), .err_code(err_code),
        .cur_node(cur_node)
    );

    function automatic logic [31:0] fold(logic md, logic [31:0] s, logic [31:0] w);
        if (md) return ({s[30:0], 1'b0} ^ (s[31] ? 32'h04C11DB7 : 32'h0) ^ w);
        return s ^ w;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // one cycle: drive at a falling edge, update the model, compare at the next
    task automatic step(string tag, logic v, logic [31:0] w, logic b,
                        logic [3:0] t, logic clr = 1'b0);
        logic [1:0] nc;
        nc = 2'b00;
        ins_valid = v; ins_word = w; ins_branch = b; branch_tgt = t; err_clear = clr;
        if (v) begin
            if (b) begin
                if (fold(lfsr_mode, m_acc, w) != m_sig[m_cur]) nc = 2'b01;
                else if (!((m_en[m_cur][0] && m_s0[m_cur] == t) ||
                           (m_en[m_cur][1] && m_s1[m_cur] == t))) nc = 2'b10;
                m_acc = '0; m_len = 0; m_cur = t;
            end else begin
                if (max_len != 0 && m_len == (int'(max_len) - 1)) begin
                    nc = 2'b11; m_len = 0;
                end else begin
                    m_len = (m_len + 1) % 256;
                end
                m_acc = fold(lfsr_mode, m_acc, w);
            end
        end
        if (!m_flag || clr) begin
            m_flag = (nc != 2'b00); m_code = nc;
        end
        @(negedge clk);
        chk(tag, {31'd0, err_flag}, {31'd0, m_flag});
        chk(tag, {30'd0, err_code}, {30'd0, m_code});
        chk(tag, {28'd0, cur_node}, {28'd0, m_cur});
        ins_valid = 1'b0; ins_branch = 1'b0; err_clear = 1'b0;
    endtask

    task automatic load(logic [3:0] n, logic [31:0] s, logic [3:0] a,
                        logic [3:0] b, logic [1:0] en);
        ref_we = 1'b1; ref_node = n; ref_sig = s; ref_succ = {b, a}; ref_succ_en = en;
        m_sig[n] = s; m_s0[n] = a; m_s1[n] = b; m_en[n] = en;
        @(negedge clk);
        ref_we = 1'b0;
    endtask

    task automatic clear(string tag);
        step(tag, 1'b0, 32'h0, 1'b0, 4'h0, 1'b1);
    endtask

    // watchdog on the whole run
    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        int seed;
        logic [31:0] A, B, C, s;
        seed = $urandom(32'd4242);
        for (int n = 0; n < NN; n++) begin
            m_sig[n] = '0; m_s0[n] = '0; m_s1[n] = '0; m_en[n] = '0;
        end
        A = 32'h1234_5678; B = 32'hCAFE_0001; C = 32'h8000_00F0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", {31'd0, err_flag}, 32'd0);
        chk("R1", {30'd0, err_code}, 32'd0);
        chk("R1", {28'd0, cur_node}, 32'd0);

        // R2: XOR node 0 -> node 1
        load(4'd0, A ^ B ^ C, 4'd1, 4'd2, 2'b11);
        step("R2", 1, A, 0, 0); step("R2", 1, B, 0, 0); step("R2", 1, C, 1, 4'd1);
        chk("R2", {31'd0, err_flag}, 32'd0);
        chk("R5", {28'd0, cur_node}, 32'd1);

        // R3: shift-register fold on node 1 -> node 0
        s = fold(1'b1, fold(1'b1, 32'h0, 32'hDEAD_BEEF), 32'hF00D_0003);
        load(4'd1, s, 4'd0, 4'd3, 2'b01);
        lfsr_mode = 1'b1;
        step("R3", 1, 32'hDEAD_BEEF, 0, 0); step("R3", 1, 32'hF00D_0003, 1, 4'd0);
        chk("R3", {31'd0, err_flag}, 32'd0);
        lfsr_mode = 1'b0;

        // R4: node 0 again from a clean accumulator
        step("R4", 1, A, 0, 0); step("R4", 1, B, 0, 0); step("R4", 1, C, 1, 4'd2);
        chk("R4", {31'd0, err_flag}, 32'd0);

        // R10: idle cycles with junk are ignored
        load(4'd2, 32'h0F0F_0000 ^ 32'h0000_7777, 4'd0, 4'd0, 2'b01);
        step("R10", 1, 32'h0F0F_0000, 0, 0);
        step("R10", 0, 32'hFFFF_FFFF, 1, 4'd9);
        step("R10", 0, 32'h1111_1111, 1, 4'd3);
        step("R10", 1, 32'h0000_7777, 1, 4'd0);
        chk("R10", {31'd0, err_flag}, 32'd0);
        chk("R10", {28'd0, cur_node}, 32'd0);

        // R5: illegal target 5
        step("R5", 1, A, 0, 0); step("R5", 1, B, 0, 0); step("R5", 1, C, 1, 4'd5);
        chk("R5", {30'd0, err_code}, 32'd2);
        chk("R5", {28'd0, cur_node}, 32'd5);
        // R8: a later signature error does not replace the held code
        step("R8", 1, 32'h55, 1, 4'd0);
        chk("R8", {30'd0, err_code}, 32'd2);
        chk("R8", {31'd0, err_flag}, 32'd1);
        clear("R9");
        chk("R9", {31'd0, err_flag}, 32'd0);

        // R9: an error in the same cycle as a clear is taken
        step("R9", 1, A, 0, 0); step("R9", 1, B, 0, 0); step("R9", 1, C, 1, 4'd9);
        chk("R9", {30'd0, err_code}, 32'd2);
        step("R9", 1, 32'h5, 1, 4'd0, 1'b1);
        chk("R9", {30'd0, err_code}, 32'd1);
        chk("R9", {31'd0, err_flag}, 32'd1);
        clear("R9");

        // R6: bad signature and bad arc together
        step("R6", 1, A, 0, 0); step("R6", 1, B, 0, 0); step("R6", 1, 32'h77, 1, 4'd7);
        chk("R6", {30'd0, err_code}, 32'd1);
        clear("R6");

        // R11: table rewrites take effect
        load(4'd7, 32'hABCD_0000, 4'd0, 4'd0, 2'b01);
        step("R11", 1, 32'hABCD_0000, 1, 4'd0);
        chk("R11", {31'd0, err_flag}, 32'd0);
        load(4'd0, A ^ B ^ C, 4'd2, 4'd2, 2'b01);
        step("R11", 1, A, 0, 0); step("R11", 1, B, 0, 0); step("R11", 1, C, 1, 4'd1);
        chk("R11", {30'd0, err_code}, 32'd2);
        clear("R11");

        // R7: length limit
        max_len = 8'd3;
        step("R7", 1, 32'h1, 0, 0); step("R7", 1, 32'h2, 0, 0);
        chk("R7", {31'd0, err_flag}, 32'd0);
        step("R7", 1, 32'h3, 0, 0);
        chk("R7", {30'd0, err_code}, 32'd3);
        step("R7", 1, 32'h4, 1, 4'd4);
        clear("R7");
        load(m_cur, 32'h10 ^ 32'h20 ^ 32'h30, 4'd6, 4'd6, 2'b10);
        step("R7", 1, 32'h10, 0, 0); step("R7", 1, 32'h20, 0, 0); step("R7", 1, 32'h30, 1, 4'd6);
        chk("R7", {31'd0, err_flag}, 32'd0);
        max_len = 8'd0;
        s = '0;
        for (int i = 0; i < 10; i++) begin
            step("R7", 1, 32'(i + 1), 0, 0);
            s = s ^ 32'(i + 1);
        end
        chk("R7", {31'd0, err_flag}, 32'd0);
        load(m_cur, s ^ 32'h99, 4'd1, 4'd1, 2'b01);
        step("R7", 1, 32'h99, 1, 4'd1);
        chk("R7", {31'd0, err_flag}, 32'd0);

        // random walk over freshly written nodes
        max_len = 8'd6;
        for (int it = 0; it < 300; it++) begin
            int          len;
            logic [31:0] w [5];
            logic [3:0]  a, b, t;
            logic [1:0]  en;
            len = 1 + int'($urandom % 5);
            lfsr_mode = $urandom % 2;
            s = '0;
            for (int i = 0; i < len; i++) begin
                w[i] = $urandom;
                s = fold(lfsr_mode, s, w[i]);
            end
            if ($urandom % 10 == 0) s = s ^ 32'h1;
            a = 4'($urandom); b = 4'($urandom);
            en = ($urandom % 8 == 0) ? 2'($urandom) : 2'b11;
            t = ($urandom % 10 == 0) ? 4'($urandom) : (($urandom % 2) ? a : b);
            load(m_cur, s, a, b, en);
            for (int i = 0; i < len; i++) begin
                step(lfsr_mode ? "R3" : "R2", 1, w[i], (i == len - 1), t);
            end
            if (m_flag) clear("R9");
        end

        summary();
    end

endmodule